// File: doc/BRIEF.md
# Level Persistence Noise Filter Timer

This block is a down-counting timer channel that decides whether an external input has stayed at its valid level long enough. Software sets the valid level (high or low) and an initial count. It then sets the enable bit. The external input first goes through a synchronizer. After that, every count-clock strobe that arrives while the input is valid takes one off the counter.

If the input falls to its invalid level, the counter freezes. When the input returns to the valid level, the counter restarts from the full initial value. So only an uninterrupted valid interval can reach the end. That end is an underflow: a count-clock strobe that arrives while the counter is already zero. On underflow the block emits a one-cycle interrupt and clears its own enable. It then ignores the input until software writes the enable bit again.

Top module: `persist_filter_timer`

## Requirements
- R1: After reset, `en_o` is 0, `count_o` is 0 and `irq_o` is 0. The valid level resets to high (1) and the initial value resets to 0.
- R2: A write (`cfg_we_i` = 1) with `cfg_en_i` = 1 does four things at the next edge: it sets `en_o`, loads `count_o` with `cfg_init_i`, and stores both `cfg_pol_i` and `cfg_init_i`. A write takes priority over counting in the same cycle.
- R3: The input is valid when its synchronized value equals the stored level bit (1 = high valid, 0 = low valid). While enabled and valid, each cycle with `cnt_tick_i` = 1 decrements a nonzero count by one. A cycle without the strobe leaves the count unchanged.
- R4: While enabled and the input is invalid, the count holds its value whatever the strobe does.
- R5: While enabled, the first cycle in which the input is valid after being invalid reloads the stored initial value. No decrement happens in that cycle.
- R6: While enabled and valid, a strobe with the count at 0 does three things: it raises `irq_o` for exactly one cycle, clears `en_o` on the same edge, and leaves the count at 0.
- R7: A write with `cfg_en_i` = 0 clears `en_o` and leaves the count at its current value.
- R8: While disabled, input changes and strobes have no effect: the count stays as it is and `irq_o` stays 0.
- R9: A change on `sig_i` passes through two synchronizer flops. It can first change the counter on the third rising edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Enable bit value written |
| cfg_pol_i | input | 1 | Valid level written (1 = high) |
| cfg_init_i | input | CNT_W | Initial count written |
| cnt_tick_i | input | 1 | Count-clock enable strobe |
| sig_i | input | 1 | External input (asynchronous) |
| en_o | output | 1 | Current enable bit |
| count_o | output | CNT_W | Current counter value |
| irq_o | output | 1 | Underflow interrupt pulse |

## Verification
The counter is driven with several input patterns:
- A steady valid level shows the decrement and the underflow stop. It also pins the exact underflow cycle.
- A valid level broken by an invalid gap tells the freeze (R4) apart from the reload (R5).
- A low-valid polarity confirms that the level test is inverted and not fixed.
- Toggling the input and strobes after a self-stop separates an idle channel from a running one.

Long random runs use rare input changes and mixed strobe density, so that some runs reach underflow and others are interrupted.

// File: rtl/pft_pkg.sv
package pft_pkg;
  localparam int unsigned PFT_SYNC_STAGES = 2;
  typedef enum logic {LVL_LOW = 1'b0, LVL_HIGH = 1'b1} level_e;
endpackage

// File: rtl/pft_sync.sv
module pft_sync #(
  parameter int unsigned STAGES = pft_pkg::PFT_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pft_level.sv
module pft_level (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_s_i,
  input  logic pol_i,
  output logic valid_o,
  output logic rise_o
);
  logic valid_q;

  assign valid_o = (sig_s_i == pol_i);
  assign rise_o  = valid_o & ~valid_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_o;
endmodule

// File: rtl/pft_core.sv
module pft_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_en_i,
  input  logic             cfg_pol_i,
  input  logic [CNT_W-1:0] cfg_init_i,
  input  logic             tick_i,
  input  logic             valid_i,
  input  logic             rise_i,
  output logic             pol_o,
  output logic             en_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic             en_q, pol_q, irq_q;
  logic [CNT_W-1:0] init_q, cnt_q;
  logic             step, at_zero;

  assign at_zero = (cnt_q == CNT_ZERO);
  assign step    = en_q & valid_i & ~rise_i & tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pol_q  <= pft_pkg::LVL_HIGH;
      init_q <= CNT_ZERO;
      cnt_q  <= CNT_ZERO;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (cfg_we_i) begin
        en_q   <= cfg_en_i;
        pol_q  <= cfg_pol_i;
        init_q <= cfg_init_i;
        if (cfg_en_i) cnt_q <= cfg_init_i;
      end else if (en_q && rise_i) begin
        cnt_q <= init_q;
      end else if (step) begin
        if (at_zero) begin
          irq_q <= 1'b1;
          en_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q - CNT_ONE;
        end
      end
    end
  end

  assign pol_o   = pol_q;
  assign en_o    = en_q;
  assign count_o = cnt_q;
  assign irq_o   = irq_q;

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_en_i |=> en_q && cnt_q == $past(cfg_init_i));
  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i && en_q && valid_i && !rise_i && tick_i && !at_zero
    |=> cnt_q == $past(cnt_q) - CNT_ONE);
  assert_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i && en_q && !valid_i |=> $stable(cnt_q) && !irq_q);
  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i && en_q && rise_i |=> cnt_q == $past(init_q));
  assert_irq_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  assert_irq_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> !en_q && at_zero);
  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i && !en_q |=> $stable(cnt_q) && !irq_q && !en_q);
endmodule

// File: rtl/persist_filter_timer.sv
module persist_filter_timer #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = pft_pkg::PFT_SYNC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_en_i,
  input  logic             cfg_pol_i,
  input  logic [CNT_W-1:0] cfg_init_i,
  input  logic             cnt_tick_i,
  input  logic             sig_i,
  output logic             en_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  logic sig_s, pol, valid, rise;

  pft_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sig_i),
    .q_o   (sig_s)
  );

  pft_level u_level (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_s_i(sig_s),
    .pol_i  (pol),
    .valid_o(valid),
    .rise_o (rise)
  );

  pft_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_we_i  (cfg_we_i),
    .cfg_en_i  (cfg_en_i),
    .cfg_pol_i (cfg_pol_i),
    .cfg_init_i(cfg_init_i),
    .tick_i    (cnt_tick_i),
    .valid_i   (valid),
    .rise_i    (rise),
    .pol_o     (pol),
    .en_o      (en_o),
    .count_o   (count_o),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/sim_persist_filter_timer.sv
module sim_persist_filter_timer;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 0, d_en = 0, d_pol = 0, tick = 0, sig = 0;
  logic [W-1:0] d_init = '0;
  logic en_o, irq_o;
  logic [W-1:0] count_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // requirement-level reference state
  logic m_s0 = 0, m_s1 = 0, m_vq = 0, m_en = 0, m_pol = 1, m_irq = 0;
  logic [W-1:0] m_init = '0, m_cnt = '0;

  always #2.5 clk = ~clk;

  persist_filter_timer #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_en_i(d_en),
    .cfg_pol_i(d_pol), .cfg_init_i(d_init), .cnt_tick_i(tick),
    .sig_i(sig), .en_o(en_o), .count_o(count_o), .irq_o(irq_o));

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic valid_of(logic s, logic p);
    return s == p;
  endfunction

  task automatic model_edge();
    logic v;
    v = valid_of(m_s1, m_pol);
    m_irq = 0;
    if (we) begin
      m_en = d_en; m_pol = d_pol; m_init = d_init;
      if (d_en) m_cnt = d_init;
    end else if (m_en && v && !m_vq) begin
      m_cnt = m_init;
    end else if (m_en && v && tick) begin
      if (m_cnt == 0) begin m_irq = 1; m_en = 0; end
      else m_cnt = m_cnt - 1;
    end
    m_vq = v; m_s1 = m_s0; m_s0 = sig;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R3 count", count_o, m_cnt);
    check("R2 en", {15'd0, en_o}, {15'd0, m_en});
    check("R6 irq", {15'd0, irq_o}, {15'd0, m_irq});
  endtask

  task automatic cycn(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic write(logic e, logic p, logic [W-1:0] v);
    we = 1; d_en = e; d_pol = p; d_init = v;
    cyc();
    we = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    #12 @(negedge clk);
    rst_n = 1'b1;
    cyc();
    check("R1 en", {15'd0, en_o}, 16'd0);
    check("R1 count", count_o, 16'd0);
    check("R1 irq", {15'd0, irq_o}, 16'd0);

    sig = 1;
    write(1, 1, 16'd3);
    check("R2 load", count_o, 16'd3);
    check("R2 en", {15'd0, en_o}, 16'd1);
    cycn(5);
    check("R3 no tick holds", count_o, 16'd3);
    tick = 1;
    cycn(3);
    check("R3 decrement", count_o, 16'd0);
    tick = 0; sig = 0;
    cycn(4);
    tick = 1;
    cycn(4);
    check("R4 invalid freezes", count_o, 16'd0);
    check("R4 no irq", {15'd0, en_o}, 16'd1);
    sig = 1;
    cycn(2);
    check("R9 two-stage delay", count_o, 16'd0);
    cyc();
    check("R5 reload", count_o, 16'd3);
    cycn(3);
    check("R3 down to zero", count_o, 16'd0);
    cyc();
    check("R6 irq", {15'd0, irq_o}, 16'd1);
    check("R6 self stop", {15'd0, en_o}, 16'd0);
    cyc();
    check("R6 one pulse", {15'd0, irq_o}, 16'd0);
    for (int i = 0; i < 8; i++) begin
      sig = i[0]; tick = i[1];
      cyc();
      check("R8 idle irq", {15'd0, irq_o}, 16'd0);
    end
    check("R8 idle count", count_o, 16'd0);
    check("R8 idle en", {15'd0, en_o}, 16'd0);
    sig = 1; tick = 0;
    cycn(4);
    write(1, 1, 16'd5);
    tick = 1;
    cycn(2);
    check("R3 steady valid", count_o, 16'd3);
    write(0, 1, 16'd5);
    cycn(4);
    check("R7 stop holds count", count_o, 16'd3);
    check("R7 en cleared", {15'd0, en_o}, 16'd0);
    write(1, 0, 16'd2);
    cycn(4);
    check("R3 low polarity high input invalid", count_o, 16'd2);
    sig = 0;
    cycn(3);
    check("R5 low polarity reload", count_o, 16'd2);
    cyc();
    check("R3 low polarity decrement", count_o, 16'd1);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      we = ($urandom_range(0, 99) < 3);
      d_en = ($urandom_range(0, 9) != 0);
      d_pol = $urandom_range(0, 1);
      d_init = ($urandom_range(0, 9) == 0) ? W'($urandom_range(0, 400))
                                           : W'($urandom_range(0, 12));
      tick = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 99) < 6) sig = ~sig;
      cyc();
    end
    we = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule